// File: doc/BRIEF.md
# Priority Ring Preemption Controller

This block decides which of four command rings the command engine executes. Each ring has a fixed priority: ring index 0 is the most urgent and index 3 the least. Whenever a submit or completion strobe arrives, the controller looks for the most urgent ring that holds work. If that ring is not the one currently executing, it arms a pending switch.

A pending switch is not taken at once. The controller waits for the execution boundary that the programmed preemption level allows: a submission boundary, a bin boundary or a draw boundary. It then runs a fixed sequence of steps, each with a fixed latency. In order, these are: an optional postamble, a save of the outgoing ring, a restore of the incoming ring, an optional preamble, a one-cycle resume, and a one-cycle interrupt. A reduced save of only the engine's own registers is used in one case: the skip-save option is set, the render mode is tile memory, and the level is 1. In that case the postamble and preamble steps run around the switch.

Each ring owns one saved read pointer. The live pointer is captured for the outgoing ring when the switch is taken. The incoming ring's saved pointer is presented for reload during the resume cycle. The actual state-saving datapath and buffers are outside the block; they appear only as the request outputs.

Top module: `prio_ring_switcher`

## Requirements
- R1: After reset, `active_ring_o` is 0. `irq_o`, `save_req_o`, `restore_req_o`, `postamble_req_o`, `preamble_req_o` and `rptr_load_o` are all low.
- R2: On a submit or completion strobe, the candidate is the lowest-indexed ring whose bit in `ring_busy_i` is 1 (index 0 = highest priority). After a completed switch, `active_ring_o` equals that candidate.
- R3: No switch is armed when no ring is busy, or when the candidate equals the active ring. Boundary strobes that follow then raise no request.
- R4: With `level_i` = 0, or the reserved code 3, a pending switch is taken only on `sub_bnd_i`. Bin and draw strobes are ignored.
- R5: With `level_i` = 1, a pending switch is taken on `bin_bnd_i` when `tile_mode_i` = 1 (tile memory), and on `draw_bnd_i` when `tile_mode_i` = 0 (system memory). The other strobes are ignored.
- R6: With `level_i` = 2, a pending switch is taken only on `draw_bnd_i`.
- R7: Timing of a taken switch, with the boundary sampled at a clock edge:
  - `save_req_o` is high for HS_LAT cycles, then `restore_req_o` is high for HS_LAT cycles.
  - Next comes one resume cycle. In it, `rptr_load_o` is high and `active_ring_o` shows the new ring.
  - In the following cycle, `irq_o` is high for exactly one cycle.
- R8: The reduced save applies only when `skip_save_i` = 1, `tile_mode_i` = 1 and `level_i` = 1 at the boundary. In that case:
  - `postamble_req_o` is high for HS_LAT cycles before the save.
  - `preamble_req_o` is high for HS_LAT cycles after the restore.
  - `ctx_light_o` is high during the save and restore.
  
  Otherwise all three stay low.
- R9: When a switch is taken, `rptr_i` is stored as the outgoing ring's saved pointer. During the resume cycle, `rptr_ld_val_o` shows the incoming ring's saved pointer, or 0 if that ring was never saved.
- R10: A submit or completion strobe that arrives during a switch sequence does not disturb it. It is re-evaluated, without any further strobe, in the cycle after the interrupt.
- R11: While a switch is pending, a new strobe re-selects the target. If the new candidate is the active ring, or no ring is busy, the pending switch is dropped. A boundary in the same cycle as such a strobe is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_busy_i | input | NRING | Per-ring non-empty flags |
| submit_i | input | 1 | Submit event strobe |
| complete_i | input | 1 | Completion event strobe |
| level_i | input | 2 | Preemption level (0 submission, 1 bin/draw, 2 draw, 3 as 0) |
| tile_mode_i | input | 1 | 1 = tile-memory rendering, 0 = system-memory rendering |
| skip_save_i | input | 1 | Request reduced save/restore |
| sub_bnd_i | input | 1 | Submission boundary strobe |
| bin_bnd_i | input | 1 | Bin boundary strobe |
| draw_bnd_i | input | 1 | Draw boundary strobe |
| rptr_i | input | PTR_W | Live read pointer of the executing ring |
| active_ring_o | output | log2(NRING) | Index of the executing ring |
| save_req_o | output | 1 | Save step in progress |
| restore_req_o | output | 1 | Restore step in progress |
| postamble_req_o | output | 1 | Postamble step in progress |
| preamble_req_o | output | 1 | Preamble step in progress |
| ctx_light_o | output | 1 | Save/restore covers engine registers only |
| rptr_load_o | output | 1 | Resume cycle: reload the read pointer |
| rptr_ld_val_o | output | PTR_W | Saved read pointer of the incoming ring |
| irq_o | output | 1 | Switch-complete interrupt pulse |

## Verification
Suppose the controller's phase state or target register goes wrong. The fault would show at the ports within one boundary plus a few HS_LAT windows, in one of these ways:
- a request that rises on a boundary the level forbids;
- a step window that is shorter or longer than HS_LAT cycles;
- `active_ring_o` naming a ring other than the most urgent busy one in the resume cycle.

A corrupted saved-pointer slot stays silent until that ring is restored. For that reason, the stimulus returns to each ring after it has been saved at least once, and compares `rptr_ld_val_o` with the pointer driven when that ring was left. A lost latched event shows as a missing save after the next allowed boundary.

// File: rtl/prs_pkg.sv
package prs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_POST,
        ST_SAVE,
        ST_REST,
        ST_PRE,
        ST_RESUME,
        ST_IRQ
    } prs_state_e;

    localparam logic [1:0] LVL_SUB  = 2'd0;
    localparam logic [1:0] LVL_BIN  = 2'd1;
    localparam logic [1:0] LVL_DRAW = 2'd2;
endpackage

// File: rtl/prs_pick.sv
module prs_pick #(
    parameter int NRING = 4,
    localparam int IW = $clog2(NRING)
) (
    input  logic [NRING-1:0] busy_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o
);
    always_comb begin
        any_o = |busy_i;
        idx_o = '0;
        for (int i = NRING - 1; i >= 0; i--) begin
            if (busy_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/prs_gate.sv
module prs_gate
    import prs_pkg::*;
(
    input  logic [1:0] level_i,
    input  logic       tile_i,
    input  logic       skip_i,
    input  logic       sub_i,
    input  logic       bin_i,
    input  logic       draw_i,
    output logic       take_o,
    output logic       light_o
);
    always_comb begin
        case (level_i)
            LVL_BIN:  take_o = tile_i ? bin_i : draw_i;
            LVL_DRAW: take_o = draw_i;
            default:  take_o = sub_i;
        endcase
        light_o = skip_i && tile_i && (level_i == LVL_BIN);
    end
endmodule

// File: rtl/prs_rptr_bank.sv
module prs_rptr_bank #(
    parameter int NRING = 4,
    parameter int PW    = 16,
    localparam int IW = $clog2(NRING)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [PW-1:0] wr_val_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [PW-1:0] rd_val_o
);
    logic [NRING*PW-1:0] flat;

    for (genvar g = 0; g < NRING; g++) begin : g_slot
        logic [PW-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  val_q <= '0;
            else if (wr_en_i && (wr_idx_i == IW'(g)))    val_q <= wr_val_i;
        end
        assign flat[g*PW +: PW] = val_q;
    end

    assign rd_val_o = flat[rd_idx_i*PW +: PW];
endmodule

// File: rtl/prio_ring_switcher.sv
module prio_ring_switcher
    import prs_pkg::*;
#(
    parameter int NRING  = 4,
    parameter int PTR_W  = 16,
    parameter int HS_LAT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NRING-1:0]         ring_busy_i,
    input  logic                     submit_i,
    input  logic                     complete_i,
    input  logic [1:0]               level_i,
    input  logic                     tile_mode_i,
    input  logic                     skip_save_i,
    input  logic                     sub_bnd_i,
    input  logic                     bin_bnd_i,
    input  logic                     draw_bnd_i,
    input  logic [PTR_W-1:0]         rptr_i,
    output logic [$clog2(NRING)-1:0] active_ring_o,
    output logic                     save_req_o,
    output logic                     restore_req_o,
    output logic                     postamble_req_o,
    output logic                     preamble_req_o,
    output logic                     ctx_light_o,
    output logic                     rptr_load_o,
    output logic [PTR_W-1:0]         rptr_ld_val_o,
    output logic                     irq_o
);
    localparam int IW = $clog2(NRING);
    localparam int CW = (HS_LAT > 1) ? $clog2(HS_LAT) : 1;
    localparam logic [CW-1:0] LAT_M1 = CW'(HS_LAT - 1);

    typedef struct packed {
        prs_state_e    st;
        logic [IW-1:0] act;
        logic [IW-1:0] tgt;
        logic          light;
        logic          pend;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          sel_any;
    logic [IW-1:0] sel_idx;
    logic          bnd_take, bnd_light;
    logic          bank_we;
    logic          evt;

    prs_pick #(.NRING(NRING)) pick_i (
        .busy_i (ring_busy_i),
        .any_o  (sel_any),
        .idx_o  (sel_idx)
    );

    prs_gate gate_i (
        .level_i (level_i),
        .tile_i  (tile_mode_i),
        .skip_i  (skip_save_i),
        .sub_i   (sub_bnd_i),
        .bin_i   (bin_bnd_i),
        .draw_i  (draw_bnd_i),
        .take_o  (bnd_take),
        .light_o (bnd_light)
    );

    prs_rptr_bank #(.NRING(NRING), .PW(PTR_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (bank_we),
        .wr_idx_i (ctl_q.act),
        .wr_val_i (rptr_i),
        .rd_idx_i (ctl_q.act),
        .rd_val_o (rptr_ld_val_o)
    );

    assign evt = submit_i | complete_i;

    always_comb begin
        ctl_d   = ctl_q;
        bank_we = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (evt || ctl_q.pend) begin
                    ctl_d.pend = 1'b0;
                    if (sel_any && (sel_idx != ctl_q.act)) begin
                        ctl_d.st  = ST_WAIT;
                        ctl_d.tgt = sel_idx;
                    end
                end
            end
            ST_WAIT: begin
                if (evt) begin
                    if (!sel_any || (sel_idx == ctl_q.act)) ctl_d.st  = ST_IDLE;
                    else                                    ctl_d.tgt = sel_idx;
                end else if (bnd_take) begin
                    bank_we     = 1'b1;
                    ctl_d.light = bnd_light;
                    ctl_d.cnt   = LAT_M1;
                    ctl_d.st    = bnd_light ? ST_POST : ST_SAVE;
                end
            end
            ST_POST, ST_SAVE, ST_REST, ST_PRE: begin
                if (evt) ctl_d.pend = 1'b1;
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.cnt = LAT_M1;
                    case (ctl_q.st)
                        ST_POST: ctl_d.st = ST_SAVE;
                        ST_SAVE: ctl_d.st = ST_REST;
                        ST_REST: ctl_d.st = ctl_q.light ? ST_PRE : ST_RESUME;
                        default: ctl_d.st = ST_RESUME;
                    endcase
                    if (ctl_d.st == ST_RESUME) ctl_d.act = ctl_q.tgt;
                end
            end
            ST_RESUME: begin
                if (evt) ctl_d.pend = 1'b1;
                ctl_d.st = ST_IRQ;
            end
            default: begin
                if (evt) ctl_d.pend = 1'b1;
                ctl_d.st    = ST_IDLE;
                ctl_d.light = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, act: '0, tgt: '0, light: 1'b0, pend: 1'b0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active_ring_o   = ctl_q.act;
    assign postamble_req_o = (ctl_q.st == ST_POST);
    assign save_req_o      = (ctl_q.st == ST_SAVE);
    assign restore_req_o   = (ctl_q.st == ST_REST);
    assign preamble_req_o  = (ctl_q.st == ST_PRE);
    assign ctx_light_o     = ctl_q.light && (save_req_o || restore_req_o);
    assign rptr_load_o     = (ctl_q.st == ST_RESUME);
    assign irq_o           = (ctl_q.st == ST_IRQ);
endmodule

// File: rtl/prs_chk.sv
module prs_chk #(
    parameter int NRING = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               level_i,
    input logic                     tile_mode_i,
    input logic                     skip_save_i,
    input logic                     sub_bnd_i,
    input logic                     bin_bnd_i,
    input logic                     draw_bnd_i,
    input logic [$clog2(NRING)-1:0] active_ring_o,
    input logic                     save_req_o,
    input logic                     restore_req_o,
    input logic                     postamble_req_o,
    input logic                     preamble_req_o,
    input logic                     ctx_light_o,
    input logic                     rptr_load_o,
    input logic                     irq_o
);
    logic allowed;
    always_comb begin
        if (level_i == 2'd2)      allowed = draw_bnd_i;
        else if (level_i == 2'd1) allowed = tile_mode_i ? bin_bnd_i : draw_bnd_i;
        else                      allowed = sub_bnd_i;
    end

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_after_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(rptr_load_o));

    assert_active_moves_on_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_ring_o) |-> rptr_load_o);

    assert_one_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req_o, restore_req_o, postamble_req_o, preamble_req_o, rptr_load_o, irq_o}));

    assert_boundary_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(save_req_o) && !$past(postamble_req_o)) |-> $past(allowed));

    assert_post_needs_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(postamble_req_o) |-> $past(skip_save_i && tile_mode_i && (level_i == 2'd1) && allowed));

    assert_post_then_light_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(postamble_req_o) |-> (save_req_o && ctx_light_o));

    assert_light_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_light_o |-> (save_req_o || restore_req_o));

    assert_pre_after_light_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preamble_req_o) |-> $past(restore_req_o && ctx_light_o));
endmodule

bind prio_ring_switcher prs_chk #(.NRING(NRING)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .level_i         (level_i),
    .tile_mode_i     (tile_mode_i),
    .skip_save_i     (skip_save_i),
    .sub_bnd_i       (sub_bnd_i),
    .bin_bnd_i       (bin_bnd_i),
    .draw_bnd_i      (draw_bnd_i),
    .active_ring_o   (active_ring_o),
    .save_req_o      (save_req_o),
    .restore_req_o   (restore_req_o),
    .postamble_req_o (postamble_req_o),
    .preamble_req_o  (preamble_req_o),
    .ctx_light_o     (ctx_light_o),
    .rptr_load_o     (rptr_load_o),
    .irq_o           (irq_o)
);

// File: tb/prio_ring_switcher_tb_top.sv
module prio_ring_switcher_tb_top;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] busy = '0;
    logic       submit = 1'b0, complete = 1'b0;
    logic [1:0] lvl = '0;
    logic       tile = 1'b0, skip = 1'b0;
    logic       sub = 1'b0, bin = 1'b0, draw = 1'b0;
    logic [7:0] rptr = '0;
    logic [1:0] active;
    logic       save_r, rest_r, post_r, pre_r, light, load, irq;
    logic [7:0] ld_val;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int act_m = 0;
    logic [7:0] slot_m [4] = '{8'h0, 8'h0, 8'h0, 8'h0};

    always #5 clk = ~clk;

    prio_ring_switcher #(.NRING(4), .PTR_W(8), .HS_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ring_busy_i(busy), .submit_i(submit),
        .complete_i(complete), .level_i(lvl), .tile_mode_i(tile), .skip_save_i(skip),
        .sub_bnd_i(sub), .bin_bnd_i(bin), .draw_bnd_i(draw), .rptr_i(rptr),
        .active_ring_o(active), .save_req_o(save_r), .restore_req_o(rest_r),
        .postamble_req_o(post_r), .preamble_req_o(pre_r), .ctx_light_o(light),
        .rptr_load_o(load), .rptr_ld_val_o(ld_val), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0] busy;
        logic [1:0] lvl;
        logic       tile;
        logic       skip;
        logic [7:0] rp;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'b0100, 2'd0, 1'b0, 1'b0, 8'h11},
        '{4'b0110, 2'd1, 1'b1, 1'b1, 8'h22},
        '{4'b1100, 2'd1, 1'b0, 1'b1, 8'h33},
        '{4'b1001, 2'd2, 1'b1, 1'b1, 8'h44},
        '{4'b1000, 2'd3, 1'b1, 1'b0, 8'h55},
        '{4'b0010, 2'd1, 1'b1, 1'b0, 8'h66}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int low_busy(input logic [3:0] b);
        for (int i = 3; i >= 0; i--) if (b[i]) low_busy = i;
        if (b == 0) low_busy = -1;
    endfunction

    task automatic do_submit(input logic [3:0] b);
        @(negedge clk); busy = b; submit = 1'b1;
        @(negedge clk); submit = 1'b0;
    endtask

    task automatic do_complete(input logic [3:0] b);
        @(negedge clk); busy = b; complete = 1'b1;
        @(negedge clk); complete = 1'b0;
    endtask

    task automatic take(input logic [1:0] lv, input logic tl, input logic sk, input logic [7:0] rp);
        int k;
        string tag;
        k   = (lv == 2'd1) ? (tl ? 1 : 2) : ((lv == 2'd2) ? 2 : 0);
        tag = (lv == 2'd1) ? "R5" : ((lv == 2'd2) ? "R6" : "R4");
        @(negedge clk);
        lvl = lv; tile = tl; skip = sk;
        sub = (k != 0); bin = (k != 1); draw = (k != 2);
        @(negedge clk);
        sub = 1'b0; bin = 1'b0; draw = 1'b0;
        chk(tag, {31'd0, save_r | post_r}, 0);
        sub = (k == 0); bin = (k == 1); draw = (k == 2); rptr = rp;
        @(negedge clk);
        sub = 1'b0; bin = 1'b0; draw = 1'b0;
        slot_m[act_m] = rp;
    endtask

    task automatic expect_seq(input int tgt, input logic lgt, input bit inj);
        if (lgt) for (int i = 0; i < LAT; i++) begin
            chk("R8", post_r, 1); @(negedge clk);
        end
        for (int i = 0; i < LAT; i++) begin
            chk("R7", save_r, 1); chk("R8", light, lgt); chk("R8", post_r, 0);
            if (inj && i == 0) begin busy = 4'b0001; submit = 1'b1; end
            if (inj && i == 1) submit = 1'b0;
            @(negedge clk);
        end
        for (int i = 0; i < LAT; i++) begin
            chk("R7", rest_r, 1); chk("R8", light, lgt); @(negedge clk);
        end
        if (lgt) for (int i = 0; i < LAT; i++) begin
            chk("R8", pre_r, 1); @(negedge clk);
        end
        chk("R8", pre_r, 0);
        chk("R7", load, 1);
        chk("R2", active, tgt);
        chk("R9", ld_val, slot_m[tgt]);
        @(negedge clk);
        chk("R7", irq, 1);
        @(negedge clk);
        chk("R7", irq, 0);
        act_m = tgt;
    endtask

    task automatic quiet(input string req);
        @(negedge clk); sub = 1'b1; bin = 1'b1; draw = 1'b1;
        @(negedge clk); sub = 1'b0; bin = 1'b0; draw = 1'b0;
        for (int i = 0; i < 2; i++) begin
            chk(req, {31'd0, save_r | post_r}, 0); @(negedge clk);
        end
        chk(req, active, act_m);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", active, 0); chk("R1", irq, 0); chk("R1", save_r, 0);
        chk("R1", rest_r, 0); chk("R1", post_r, 0); chk("R1", pre_r, 0); chk("R1", load, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", active, 0);

        // table-driven switches (R2, R4, R5, R6, R7, R8, R9)
        for (int v = 0; v < 6; v++) begin
            int t;
            logic lg;
            t  = low_busy(VEC[v].busy);
            lg = VEC[v].skip && VEC[v].tile && (VEC[v].lvl == 2'd1);
            do_submit(VEC[v].busy);
            take(VEC[v].lvl, VEC[v].tile, VEC[v].skip, VEC[v].rp);
            expect_seq(t, lg, 1'b0);
        end

        // R3: candidate equals active ring, then no ring busy
        do_submit(4'b0010);
        quiet("R3");
        do_complete(4'b0000);
        quiet("R3");

        // R11: retarget while pending
        lvl = 2'd0; skip = 1'b0;
        do_submit(4'b1000);
        do_submit(4'b0100);
        take(2'd0, 1'b0, 1'b0, 8'h77);
        expect_seq(2, 1'b0, 1'b0);

        // R11: pending switch dropped when candidate returns to active
        do_submit(4'b0001);
        do_complete(4'b0100);
        quiet("R11");

        // R10: event latched during the save, re-evaluated after interrupt
        do_submit(4'b1000);
        take(2'd0, 1'b0, 1'b0, 8'h88);
        expect_seq(3, 1'b0, 1'b1);
        take(2'd0, 1'b0, 1'b0, 8'h99);
        expect_seq(0, 1'b0, 1'b0);
        chk("R10", active, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule